// File: doc/BRIEF.md
# Prioritised Interrupt Level Controller

This block gathers fifteen interrupt sources, numbered 1 to 15, into a set of sticky pending bits. A mask register hides individual levels, and the highest level that is still active is presented to the processor as a four-bit request level, where 0 means no request. When the processor takes an interrupt it returns an acknowledge with the level number, and the block retires that level. Level 0 never exists as a source.

For test software, a force register can inject interrupts without any real source. The force register joins the active set only while a test-mode bit is set. While test mode is on, an acknowledge retires a forced level in preference to the pending bit of the same level. A simple register port gives access to the pending, mask, clear, force and test-control registers. It has an address, a write strobe and a read strobe. Any write that sets a reserved bit produces a one-cycle parity-error pulse.

The output stage is a two-state machine. It sits in `ST_IDLE` while no level is requested and in `ST_REQ` while one is. The transition `IDLE_TO_REQ` is taken when the encoded level becomes non-zero. The transition `REQ_TO_IDLE` is taken when it returns to zero. Both transitions happen at the same edge that loads the new level into the output register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A one-cycle pulse on `src_pulse[n]` (n from 1 to 15) sets pending bit n at the next clock edge. `src_pulse[0]` is ignored, and pending bit 0 always reads 0.
- R2: The mask register keeps only bits 14:1 of a write. A set mask bit stops that level from requesting. Level 15 cannot be masked, and mask bits 15 and 0 always read 0.
- R3: `irq_level` is the highest set bit of (pending OR force-if-test) AND NOT mask, searched from 15 down to 1, or 0 if no bit is set. It is registered, so it follows a register change one clock later.
- R4: A write to the clear register (address 2) clears every pending bit in 15:1 that is written as 1 and leaves the other pending bits unchanged. The clear register reads as 0.
- R5: The force register (address 3, bits 15:1) is always writable and readable. It joins the active set only while test-control bit 19 (address 4) is 1.
- R6: An acknowledge of level n (`ack_valid` high, `ack_level` = n, n from 1 to 15) clears force bit n if test mode is on and force bit n is set, and leaves pending bit n unchanged. Otherwise it clears pending bit n. An acknowledge of level 0 has no effect.
- R7: When a source pulse and an acknowledge of the same level arrive in the same cycle, the pending bit stays set. A source pulse also wins over a clear write to the same bit.
- R8: `par_err` pulses high for one cycle, one clock after a write that sets a reserved bit. For the mask register the reserved bits are 31:15 and 0. For the clear and force registers they are 31:16 and 0. The permitted bits of such a write still take effect.
- R9: The register map is: 0 pending (read-only), 1 mask, 2 clear (write-only), 3 force, 4 test control (bit 19 only). `reg_rdata` shows the addressed register in the same cycle while `reg_rd` is high, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 16 | Source pulses, bit n for level n; bit 0 is ignored |
| ack_valid | input | 1 | Acknowledge strobe from the processor |
| ack_level | input | 4 | Level being acknowledged |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| irq_level | output | 4 | Registered request level, 0 for none |
| par_err | output | 1 | One-cycle pulse after a write to reserved bits |

## Verification
Single sources show that a pulse reaches the output one clock after it reaches the pending register. Pairs of simultaneous sources show that the higher level wins. Masking the winner shows that the next level down comes through, and masking everything shows that level 15 still gets through. A forced level that is higher than a pending level tells whether the test-mode bit gates the force register. Acknowledging a level that is both forced and pending tells apart the two clearing paths. Collisions of source with acknowledge, and writes with reserved bits set against clean writes, cover the same-cycle precedence and the parity-error pulse.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int TEST_BIT = 19;

    typedef enum logic [ADDR_W-1:0] {
        A_PEND  = 3'd0,
        A_MASK  = 3'd1,
        A_CLEAR = 3'd2,
        A_FORCE = 3'd3,
        A_TEST  = 3'd4
    } reg_addr_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } req_state_e;
endpackage

// File: rtl/irq_prio_regif.sv
module irq_prio_regif
    import irq_prio_pkg::*;
#(
    parameter int NUM_LEVELS = 15,
    localparam int VEC_W = NUM_LEVELS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [VEC_W-1:0]  pend_q,
    input  logic [VEC_W-1:0]  frc_q,
    output logic [VEC_W-1:0]  mask_q,
    output logic              test_q,
    output logic              clr_we,
    output logic              frc_we,
    output logic [VEC_W-1:0]  wvec,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              par_err
);
    localparam logic [DATA_W-1:0] MASK_KEEP = ((DATA_W'(1) << NUM_LEVELS) - DATA_W'(1)) & ~DATA_W'(1);
    localparam logic [DATA_W-1:0] VEC_KEEP  = ((DATA_W'(1) << VEC_W) - DATA_W'(1)) & ~DATA_W'(1);

    logic mask_we, test_we, rsv_hit;

    always_comb begin
        mask_we = reg_wr && (reg_addr == A_MASK);
        clr_we  = reg_wr && (reg_addr == A_CLEAR);
        frc_we  = reg_wr && (reg_addr == A_FORCE);
        test_we = reg_wr && (reg_addr == A_TEST);
        wvec    = reg_wdata[VEC_W-1:0] & VEC_KEEP[VEC_W-1:0];
        rsv_hit = (mask_we && ((reg_wdata & ~MASK_KEEP) != '0)) ||
                  ((clr_we || frc_we) && ((reg_wdata & ~VEC_KEEP) != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            test_q  <= 1'b0;
            par_err <= 1'b0;
        end else begin
            par_err <= rsv_hit;
            if (mask_we) mask_q <= reg_wdata[VEC_W-1:0] & MASK_KEEP[VEC_W-1:0];
            if (test_we) test_q <= reg_wdata[TEST_BIT];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                A_PEND:  reg_rdata = DATA_W'(pend_q);
                A_MASK:  reg_rdata = DATA_W'(mask_q);
                A_FORCE: reg_rdata = DATA_W'(frc_q);
                A_TEST:  reg_rdata = DATA_W'(test_q) << TEST_BIT;
                default: reg_rdata = '0;
            endcase
        end
    end

    p_mask_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[0] && !mask_q[VEC_W-1]);
    p_parity_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $past(reg_wr));
endmodule

// File: rtl/irq_prio_pend.sv
module irq_prio_pend #(
    parameter int NUM_LEVELS = 15,
    localparam int VEC_W = NUM_LEVELS + 1,
    localparam int LVL_W = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] src_pulse,
    input  logic             ack_valid,
    input  logic [LVL_W-1:0] ack_level,
    input  logic             test_q,
    input  logic             clr_we,
    input  logic             frc_we,
    input  logic [VEC_W-1:0] wvec,
    output logic [VEC_W-1:0] pend_q,
    output logic [VEC_W-1:0] frc_q
);
    logic [VEC_W-1:0] ack_dec, frc_take, pend_ack, clr_vec, src_vec;

    genvar gi;
    generate
        for (gi = 0; gi < VEC_W; gi++) begin : g_lvl
            if (gi == 0) begin : g_zero
                assign ack_dec[gi] = 1'b0;
            end else begin : g_real
                assign ack_dec[gi] = ack_valid && (ack_level == LVL_W'(gi));
            end
        end
    endgenerate

    always_comb begin
        frc_take = ack_dec & frc_q & {VEC_W{test_q}};
        pend_ack = ack_dec & ~frc_take;
        clr_vec  = clr_we ? wvec : '0;
        src_vec  = src_pulse & ~VEC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            frc_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec & ~pend_ack) | src_vec;
            if (frc_we) frc_q <= wvec;
            else        frc_q <= frc_q & ~frc_take;
        end
    end

    p_bit0_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0] && !frc_q[0]);

    generate
        for (gi = 1; gi < VEC_W; gi++) begin : g_chk
            p_src_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
                src_pulse[gi] |=> pend_q[gi]);
            p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_valid && ack_level == LVL_W'(gi) && !src_pulse[gi] && !(test_q && frc_q[gi]))
                |=> !pend_q[gi]);
            p_force_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_valid && ack_level == LVL_W'(gi) && test_q && frc_q[gi] && !frc_we)
                |=> (!frc_q[gi] && (pend_q[gi] == $past(pend_q[gi] || src_pulse[gi]) || $past(clr_we))));
        end
    endgenerate
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_prio_pkg::*;
#(
    parameter int NUM_LEVELS = 15,
    localparam int VEC_W = NUM_LEVELS + 1,
    localparam int LVL_W = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] pend_q,
    input  logic [VEC_W-1:0] frc_q,
    input  logic [VEC_W-1:0] mask_q,
    input  logic             test_q,
    output logic [LVL_W-1:0] irq_level
);
    logic [VEC_W-1:0] active;
    logic [LVL_W-1:0] enc;
    req_state_e       state_q, state_d;

    always_comb begin
        active = (pend_q | (test_q ? frc_q : '0)) & ~mask_q & ~VEC_W'(1);
        enc    = '0;
        for (int i = 1; i < VEC_W; i++) begin
            if (active[i]) enc = LVL_W'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enc != '0) state_d = ST_REQ;
            ST_REQ:  if (enc == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            irq_level <= '0;
        else if (state_d == ST_REQ) irq_level <= enc;
        else                   irq_level <= '0;
    end

    p_level_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> ((($past(active)) >> irq_level) & VEC_W'(1)) != '0);
    p_state_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ) == (irq_level != '0));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_LEVELS = 15,
    localparam int VEC_W = NUM_LEVELS + 1,
    localparam int LVL_W = $clog2(VEC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VEC_W-1:0]  src_pulse,
    input  logic              ack_valid,
    input  logic [LVL_W-1:0]  ack_level,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [LVL_W-1:0]  irq_level,
    output logic              par_err
);
    logic [VEC_W-1:0] pend_q, frc_q, mask_q, wvec;
    logic             test_q, clr_we, frc_we;

    irq_prio_regif #(.NUM_LEVELS(NUM_LEVELS)) u_regif (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend_q(pend_q),
        .frc_q(frc_q), .mask_q(mask_q), .test_q(test_q), .clr_we(clr_we),
        .frc_we(frc_we), .wvec(wvec), .reg_rdata(reg_rdata), .par_err(par_err)
    );

    irq_prio_pend #(.NUM_LEVELS(NUM_LEVELS)) u_pend (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .ack_valid(ack_valid),
        .ack_level(ack_level), .test_q(test_q), .clr_we(clr_we),
        .frc_we(frc_we), .wvec(wvec), .pend_q(pend_q), .frc_q(frc_q)
    );

    irq_prio_enc #(.NUM_LEVELS(NUM_LEVELS)) u_enc (
        .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .frc_q(frc_q),
        .mask_q(mask_q), .test_q(test_q), .irq_level(irq_level)
    );

    p_collide_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_level != '0 && src_pulse[ack_level]) |=> pend_q[$past(ack_level)]);
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_pulse = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_level = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [3:0]  irq_level;
    logic        par_err;
    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .ack_valid(ack_valid),
        .ack_level(ack_level), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_level(irq_level),
        .par_err(par_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] v);
        src_pulse = v;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic ack(input logic [3:0] l, input logic [15:0] v);
        ack_valid = 1'b1; ack_level = l; src_pulse = v;
        @(negedge clk);
        ack_valid = 1'b0; ack_level = '0; src_pulse = '0;
    endtask

    task automatic scrub();
        wr(3'd4, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'hFFFE);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R3 reset level", 32'(irq_level), 32'h0);
        check("R8 reset par_err", 32'(par_err), 32'h0);
        rd(3'd0, d); check("R9 reset pending", d, 32'h0);
        rd(3'd1, d); check("R2 reset mask", d, 32'h0);
        check("R9 idle rdata", reg_rdata, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] d;
        scrub();
        pulse(16'h0020);
        rd(3'd0, d); check("R1 pending bit5", d, 32'h0020);
        check("R3 latency old level", 32'(irq_level), 32'h0);
        @(negedge clk);
        check("R3 level 5", 32'(irq_level), 32'd5);
        pulse(16'h0001);
        rd(3'd0, d); check("R1 src bit0 ignored", d, 32'h0020);
    endtask

    task automatic t_prio_mask();
        logic [31:0] d;
        scrub();
        pulse(16'h0208);
        @(negedge clk);
        check("R3 highest of 3,9", 32'(irq_level), 32'd9);
        wr(3'd1, 32'h0200);
        check("R8 clean mask write", 32'(par_err), 32'h0);
        @(negedge clk);
        check("R2 mask 9 gives 3", 32'(irq_level), 32'd3);
        wr(3'd1, 32'hFFFF);
        check("R8 mask reserved", 32'(par_err), 32'h1);
        rd(3'd1, d); check("R2 mask readback", d, 32'h7FFE);
        @(negedge clk);
        check("R8 pulse one cycle", 32'(par_err), 32'h0);
        check("R2 all masked", 32'(irq_level), 32'd0);
        pulse(16'h8000);
        @(negedge clk);
        check("R2 level15 unmaskable", 32'(irq_level), 32'd15);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        scrub();
        pulse(16'h8208);
        wr(3'd2, 32'h0208);
        rd(3'd0, d); check("R4 clear selected", d, 32'h8000);
        rd(3'd2, d); check("R4 clear reads 0", d, 32'h0);
        wr(3'd2, 32'h0001_8000);
        check("R8 clear reserved", 32'(par_err), 32'h1);
        rd(3'd0, d); check("R8 permitted bits applied", d, 32'h0);
        src_pulse = 16'h0040; wr(3'd2, 32'h0040); src_pulse = '0;
        rd(3'd0, d); check("R7 source beats clear", d, 32'h0040);
    endtask

    task automatic t_ack();
        logic [31:0] d;
        scrub();
        pulse(16'h0080);
        ack(4'd7, 16'h0);
        rd(3'd0, d); check("R6 ack clears pending", d, 32'h0);
        pulse(16'h0080);
        ack(4'd0, 16'h0);
        rd(3'd0, d); check("R6 ack level0 no effect", d, 32'h0080);
        ack(4'd7, 16'h0080);
        rd(3'd0, d); check("R7 source with ack keeps", d, 32'h0080);
    endtask

    task automatic t_force();
        logic [31:0] d;
        scrub();
        pulse(16'h0400);
        wr(3'd3, 32'h1000);
        rd(3'd3, d); check("R5 force readback", d, 32'h1000);
        @(negedge clk);
        check("R5 force gated off", 32'(irq_level), 32'd10);
        wr(3'd4, 32'h0008_0000);
        rd(3'd4, d); check("R9 test bit19", d, 32'h0008_0000);
        @(negedge clk);
        check("R5 force active", 32'(irq_level), 32'd12);
        ack(4'd12, 16'h0);
        rd(3'd3, d); check("R6 ack clears force", d, 32'h0);
        @(negedge clk);
        check("R6 back to 10", 32'(irq_level), 32'd10);
        wr(3'd3, 32'h0400);
        ack(4'd10, 16'h0);
        rd(3'd3, d); check("R6 force10 cleared", d, 32'h0);
        rd(3'd0, d); check("R6 pending10 kept", d, 32'h0400);
        ack(4'd10, 16'h0);
        rd(3'd0, d); check("R6 second ack pending", d, 32'h0);
        @(negedge clk);
        check("R3 level idle", 32'(irq_level), 32'd0);
        wr(3'd3, 32'h0000_0001);
        check("R8 force reserved", 32'(par_err), 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_prio_mask();
        t_clear();
        t_ack();
        t_force();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule